// File: doc/BRIEF.md
# Distributor Control and Identification Slice

This block is the small register slice at the base of an interrupt distributor's register window. It holds the single global enable for the distributor and presents two read-only words. The type word reports, from the elaboration parameters, how many 32-interrupt lines the distributor implements and how many CPUs it serves. The identification word carries a fixed product code and implementer code. A 32-bit register bus selects one of the words with a two-bit word offset, which corresponds to byte-offset bits [3:2].

Software turns the distributor on by writing 1 to bit 0 of the control word. The block emits a one-cycle wake pulse toward the CPU interfaces only when the enable goes from off to on. The CPU interfaces use this pulse to re-examine work that was pending while the distributor was off. Reads are registered: the data appears one cycle after the request, qualified by a valid strobe.

Top module: `dist_ctl_regs`

## Requirements
- R1: A read request (`bus_sel`=1, `bus_wr`=0) yields `bus_rvalid`=1 with the selected word on `bus_rdata` in the cycle after the request edge, and `bus_rvalid`=0 after any cycle with no read request. Word offset 0 selects control, 1 selects type, and 2 selects identification.
- R2: A read at word offset 3 returns all zeros.
- R3: The control word reads as the enable in bit 0, with bits [31:1] zero.
- R4: A write to word offset 0 loads the enable from `bus_wdata[0]`, and `dist_on` shows the new value after that edge. Bits [31:1] of the write data have no effect.
- R5: A control write that changes the enable from 0 to 1 raises `wake_cpus` for exactly one cycle. The pulse starts on the same edge at which `dist_on` first reads 1.
- R6: A control write of 1 while the enable is already 1 produces no wake pulse, and neither does a write of 0.
- R7: The type word has bits [4:0] = (NUM_SHARED+32)/32 - 1, bits [7:5] = NUM_CPUS - 1, and bits [31:8] zero. With the default parameters this word is 0x00000062.
- R8: The identification word holds PRODUCT_ID in bits [31:24] and IMPL_CODE in bits [11:0], with all other bits zero. With the default parameters this word is 0x4B00043B.
- R9: Writes to word offsets 1, 2 and 3 leave the enable, the type word and the identification word unchanged, and they raise no wake pulse.
- R10: While reset is asserted and just after it, `dist_on`, `wake_cpus` and `bus_rvalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 2 | Word offset (byte offset bits [3:2]) |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| bus_rdata | output | 32 | Read data |
| dist_on | output | 1 | Global distributor enable |
| wake_cpus | output | 1 | One-cycle pulse on enable going 0 to 1 |

## Verification
On every cycle, the in-RTL assertions check the following:
- A wake pulse coincides with a fresh rise of the enable.
- Every rise of the enable carries a pulse.
- Writes outside the control word leave the enable stable.
- The read strobe follows the read request by one cycle.
- Offset 3 reads as zero.

The bench scenarios show the rest, which are values rather than relations:
- the exact type and identification words computed from the parameters;
- the control word's bit layout;
- the pulse being absent for repeated writes of 1 and for writes of 0;
- the enable surviving a write carrying stray upper data bits.

// File: rtl/dist_ctl_regs.sv
module dist_ctl_regs #(
  parameter int          NUM_CPUS   = 4,
  parameter int          NUM_SHARED = 64,
  parameter logic [7:0]  PRODUCT_ID = 8'h4B,
  parameter logic [11:0] IMPL_CODE  = 12'h43B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_word,
  input  logic [31:0] bus_wdata,
  output logic        bus_rvalid,
  output logic [31:0] bus_rdata,
  output logic        dist_on,
  output logic        wake_cpus
);

  localparam int          LINES      = (NUM_SHARED + 32) / 32;
  localparam logic [31:0] TYPE_WORD  = {24'd0, 3'(NUM_CPUS - 1), 5'(LINES - 1)};
  localparam logic [31:0] IDENT_WORD = {PRODUCT_ID, 12'd0, IMPL_CODE};

  initial begin
    assert (NUM_CPUS >= 1 && NUM_CPUS <= 8) else $error("NUM_CPUS out of range");
    assert (NUM_SHARED % 32 == 0 && LINES <= 32) else $error("NUM_SHARED invalid");
  end

  logic rd_req, ctl_wr;
  logic [31:0] rd_mux;
  logic unused_wdata;

  assign rd_req       = bus_sel && !bus_wr;
  assign ctl_wr       = bus_sel && bus_wr && (bus_word == 2'd0);
  assign unused_wdata = ^bus_wdata[31:1];

  always_comb begin
    case (bus_word)
      2'd0:    rd_mux = {31'd0, dist_on};
      2'd1:    rd_mux = TYPE_WORD;
      2'd2:    rd_mux = IDENT_WORD;
      default: rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dist_on   <= 1'b0;
      wake_cpus <= 1'b0;
    end else begin
      wake_cpus <= ctl_wr && bus_wdata[0] && !dist_on;
      if (ctl_wr) dist_on <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= 32'd0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_mux;
    end
  end

  assert_wake_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_cpus |-> (dist_on && !$past(dist_on)));

  assert_rise_wakes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dist_on) |-> wake_cpus);

  assert_ro_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_word != 2'd0) |=> ($stable(dist_on) && !wake_cpus));

  assert_rvalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  assert_no_rvalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);

  assert_hole_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_word == 2'd3) |=> (bus_rdata == 32'd0));

endmodule

// File: tb/sim_dist_ctl_regs.sv
module sim_dist_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_word = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic        bus_rvalid, dist_on, wake_cpus;
  logic [31:0] bus_rdata;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [31:0] EXP_TYPE  = 32'h0000_0062;
  localparam logic [31:0] EXP_IDENT = 32'h4B00_043B;

  always #5 clk = ~clk;

  dist_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .dist_on(dist_on), .wake_cpus(wake_cpus)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("R1 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input logic [1:0] w, input logic [31:0] exp, input string tag);
    bus_sel = 1; bus_wr = 0; bus_word = w;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  // control write, then check enable and wake pulse cycle by cycle
  task automatic wr_ctl(input logic [31:0] d, input logic exp_on, input logic exp_wake, input string tag);
    wr(2'd0, d);
    check({tag, " on"}, {31'd0, dist_on}, {31'd0, exp_on});
    check({tag, " wake"}, {31'd0, wake_cpus}, {31'd0, exp_wake});
    @(negedge clk);
    check({tag, " wake one cycle"}, {31'd0, wake_cpus}, 32'd0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset dist_on", {31'd0, dist_on}, 32'd0);
    check("R10 reset wake", {31'd0, wake_cpus}, 32'd0);
    check("R10 reset rvalid", {31'd0, bus_rvalid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R10 after reset dist_on", {31'd0, dist_on}, 32'd0);

    rd(2'd0, 32'd0, "R3 ctrl off");
    rd(2'd1, EXP_TYPE, "R7 type word");
    rd(2'd2, EXP_IDENT, "R8 ident word");
    rd(2'd3, 32'd0, "R2 hole");
    @(negedge clk);
    check("R1 rvalid drops", {31'd0, bus_rvalid}, 32'd0);

    wr_ctl(32'h0000_0001, 1'b1, 1'b1, "R5 enable rise");
    rd(2'd0, 32'd1, "R3 ctrl on");
    wr_ctl(32'h0000_0001, 1'b1, 1'b0, "R6 rewrite 1");
    wr_ctl(32'hFFFF_FFFF, 1'b1, 1'b0, "R6 rewrite all ones");
    rd(2'd0, 32'd1, "R4 upper bits ignored");

    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h0);
    check("R9 enable kept", {31'd0, dist_on}, 32'd1);
    check("R9 no wake", {31'd0, wake_cpus}, 32'd0);
    rd(2'd1, EXP_TYPE, "R9 type unchanged");
    rd(2'd2, EXP_IDENT, "R9 ident unchanged");

    wr_ctl(32'hFFFF_FFFE, 1'b0, 1'b0, "R6 clear");
    rd(2'd0, 32'd0, "R4 ctrl cleared");
    wr(2'd1, 32'hFFFF_FFFF);
    check("R9 type write no enable", {31'd0, dist_on}, 32'd0);
    wr_ctl(32'h0000_0003, 1'b1, 1'b1, "R5 second rise");

    // back-to-back reads through the scoreboard
    rd(2'd2, EXP_IDENT, "R1 burst ident");
    rd(2'd0, 32'd1, "R1 burst ctrl");
    rd(2'd3, 32'd0, "R2 burst hole");
    rd(2'd1, EXP_TYPE, "R1 burst type");
    repeat (2) @(negedge clk);
    check("R1 queue drained", exp_q.size(), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule